// File: doc/BRIEF.md
# Pixel to bus cycle packer

This block sits between a pixel source and the strobe generator of a parallel display bus. It accepts pixels of 12, 16, 18 or 24 bits on a ready/valid stream and cuts each one into a short run of bus words. Each word fills the lowest 8, 9, 12 or 16 lines of the output. The words leave on a second ready/valid stream, and the strobe generator turns each accepted word into one bus cycle.

Three static settings define the split: the pixel depth, the number of bus lines and the cycle format. A pixel can take one, two or three bus cycles. In the pair format, two pixels share three cycles, and the middle cycle carries the tail of the first pixel together with the head of the second. Bits are always sent most significant first. A setting that does not match the arithmetic rule for its depth and line count raises an error flag and halts the stream.

Top module: `pix_bus_packer`

## Requirements
- R1: Depth codes are 0=12, 1=16, 2=18 and 3=24 bits. Line codes are 0=8, 1=9, 2=12 and 3=16 lines. Format codes are 0 (one cycle per pixel), 1 (two cycles), 2 (three cycles) and 3 (three cycles per two pixels). The required format is depth/lines minus one when depth/lines is a whole number from 1 to 3. Otherwise it is code 3 when 2*depth/lines equals exactly 3. cfg_err is high whenever cfg_fmt differs from the required format, or when no format is allowed.
- R2: While cfg_err is high, out_valid and in_ready stay low and the cycle position does not advance.
- R3: In formats 1 and 2, a pixel of depth D on L lines gives D/L words. Word k carries pixel bits D-1-k*L down to D-(k+1)*L on lines L-1..0, so 16 bits on 8 lines send the high byte first. Lines at and above L read zero.
- R4: In format 0, the whole pixel goes out as one word on the low lines.
- R5: In format 3, pixels A and B form a 2*D-bit string with A first. The three words are consecutive L-bit slices of that string, taken from the most significant end. The middle word holds the low L/2 bits of A on its upper half-lines and the top L/2 bits of B on its lower half-lines.
- R6: in_ready is high only in a cycle where out_valid and out_ready are both high. In formats 0 to 2 it comes with the last word of the pixel. In format 3 it comes with the first word, when A is stored, and again with the third word.
- R7: out_valid follows in_valid when the configuration is legal. While out_ready is low the word does not change and no cycle position is lost.
- R8: Input bits at and above the selected depth have no effect on any word.
- R9: After reset the block is at the first word of a pixel and no pixel is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_depth | input | 2 | Pixel depth code |
| cfg_lanes | input | 2 | Bus line count code |
| cfg_fmt | input | 2 | Cycle format code |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Pixel consumed this cycle |
| in_pix | input | PIX_W | Pixel value, right aligned |
| out_valid | output | 1 | Bus word present |
| out_ready | input | 1 | Strobe generator takes the word |
| out_word | output | BUS_W | Bus word on the low lines |
| cfg_err | output | 1 | Configuration combination illegal |

## Verification
The assertions assume that the three configuration codes change only while the block sits at the first word of a pixel. They also assume that in_pix and in_valid stay unchanged while a presented pixel has not been consumed. The stability check under backpressure depends on both. The bench changes configuration only between complete pixel runs and holds the pixel steady while the output is stalled. It exercises every legal depth and line pairing across all four formats, and it includes illegal and mismatched settings.

// File: rtl/pbp_pkg.sv
package pbp_pkg;
  localparam int BPP_W = 6;
  localparam int LN_W  = 5;

  typedef enum logic [1:0] {DEP12 = 2'd0, DEP16 = 2'd1, DEP18 = 2'd2, DEP24 = 2'd3} depth_e;
  typedef enum logic [1:0] {LN8 = 2'd0, LN9 = 2'd1, LN12 = 2'd2, LN16 = 2'd3} lanes_e;
  typedef enum logic [1:0] {FMT_1 = 2'd0, FMT_2 = 2'd1, FMT_3 = 2'd2, FMT_PAIR = 2'd3} fmt_e;

  function automatic logic [BPP_W-1:0] depth_bits(depth_e d);
    case (d)
      DEP12:   return BPP_W'(12);
      DEP16:   return BPP_W'(16);
      DEP18:   return BPP_W'(18);
      default: return BPP_W'(24);
    endcase
  endfunction

  function automatic logic [LN_W-1:0] lane_bits(lanes_e m);
    case (m)
      LN8:     return LN_W'(8);
      LN9:     return LN_W'(9);
      LN12:    return LN_W'(12);
      default: return LN_W'(16);
    endcase
  endfunction

  // {allowed, format}: the format the arithmetic rule demands
  function automatic logic [2:0] rule_fmt(logic [BPP_W-1:0] bpp, logic [LN_W-1:0] ln);
    int b;
    int l;
    b = int'(bpp);
    l = int'(ln);
    if ((b % l) == 0 && (b / l) >= 1 && (b / l) <= 3)
      return {1'b1, 2'((b / l) - 1)};
    else if (((2 * b) % l) == 0 && ((2 * b) / l) == 3)
      return {1'b1, FMT_PAIR};
    else
      return 3'b000;
  endfunction

  function automatic logic [1:0] fmt_cycles(fmt_e f);
    case (f)
      FMT_1:   return 2'd1;
      FMT_2:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/pbp_cfg_decode.sv
module pbp_cfg_decode
  import pbp_pkg::*;
(
  input  logic [1:0]       cfg_depth,
  input  logic [1:0]       cfg_lanes,
  input  logic [1:0]       cfg_fmt,
  output logic             legal,
  output logic [BPP_W-1:0] bpp,
  output logic [LN_W-1:0]  lines,
  output logic [1:0]       ncyc,
  output logic             pair
);
  logic [2:0] rule;

  assign bpp   = depth_bits(depth_e'(cfg_depth));
  assign lines = lane_bits(lanes_e'(cfg_lanes));
  assign rule  = rule_fmt(bpp, lines);
  assign legal = rule[2] && (rule[1:0] == cfg_fmt);
  assign ncyc  = fmt_cycles(fmt_e'(cfg_fmt));
  assign pair  = (cfg_fmt == FMT_PAIR);

  // R1: a legal setting moves exactly the pixel bits of its group
  always_comb begin
    if (legal)
      p_bits_cover_r1: assert (int'(ncyc) * int'(lines) == (pair ? 2 : 1) * int'(bpp));
  end
endmodule

// File: rtl/pbp_phase_ctrl.sv
module pbp_phase_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [1:0] ncyc,
  output logic [1:0] phase,
  output logic       last
);
  assign last = (phase == ncyc - 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= 2'd0;
    else if (fire)
      phase <= last ? 2'd0 : phase + 2'd1;
  end

  // R3: position never passes the cycle count of the format
  p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase < ncyc);

  // R7: no handoff, no movement
  p_phase_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(phase));
endmodule

// File: rtl/pbp_slice_mux.sv
module pbp_slice_mux
  import pbp_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int BUS_W = 16
) (
  input  logic [PIX_W-1:0] pix,
  input  logic [PIX_W-1:0] held,
  input  logic [1:0]       phase,
  input  logic [BPP_W-1:0] bpp,
  input  logic [LN_W-1:0]  lines,
  input  logic             pair,
  output logic [BUS_W-1:0] word
);
  localparam int GRP_W = 2 * PIX_W;

  function automatic logic [BUS_W-1:0] lane_mask(logic [LN_W-1:0] n);
    return (BUS_W'(1) << n) - BUS_W'(1);
  endfunction

  logic [GRP_W-1:0] grp;
  int               gbits;
  int               shift;

  always_comb begin
    if (pair) begin
      if (phase == 2'd0)
        grp = GRP_W'(pix) << bpp;
      else
        grp = (GRP_W'(held) << bpp) | GRP_W'(pix);
      gbits = 2 * int'(bpp);
    end else begin
      grp   = GRP_W'(pix);
      gbits = int'(bpp);
    end
    shift = gbits - (int'(phase) + 1) * int'(lines);
    if (shift < 0)
      shift = 0;
    word = BUS_W'(grp >> shift) & lane_mask(lines);
  end
endmodule

// File: rtl/pix_bus_packer.sv
module pix_bus_packer
  import pbp_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_depth,
  input  logic [1:0]       cfg_lanes,
  input  logic [1:0]       cfg_fmt,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BUS_W-1:0] out_word,
  output logic             cfg_err
);
  logic             legal;
  logic [BPP_W-1:0] bpp;
  logic [LN_W-1:0]  lines;
  logic [1:0]       ncyc;
  logic             pair;
  logic [1:0]       phase;
  logic             last;
  logic             fire;
  logic             take_first;
  logic [PIX_W-1:0] pix_m;
  logic [PIX_W-1:0] held;

  pbp_cfg_decode u_dec (
    .cfg_depth (cfg_depth),
    .cfg_lanes (cfg_lanes),
    .cfg_fmt   (cfg_fmt),
    .legal     (legal),
    .bpp       (bpp),
    .lines     (lines),
    .ncyc      (ncyc),
    .pair      (pair)
  );

  assign cfg_err    = !legal;
  assign out_valid  = in_valid && legal;
  assign fire       = out_valid && out_ready;
  assign take_first = pair && (phase == 2'd0);
  assign in_ready   = fire && (last || take_first);
  assign pix_m      = in_pix & ((PIX_W'(1) << bpp) - PIX_W'(1));

  pbp_phase_ctrl u_ph (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .ncyc  (ncyc),
    .phase (phase),
    .last  (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      held <= '0;
    else if (fire && take_first)
      held <= pix_m;
  end

  pbp_slice_mux #(.PIX_W(PIX_W), .BUS_W(BUS_W)) u_mux (
    .pix   (pix_m),
    .held  (held),
    .phase (phase),
    .bpp   (bpp),
    .lines (lines),
    .pair  (pair),
    .word  (out_word)
  );

  // R2: illegal setting keeps both streams quiet
  p_err_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!out_valid && !in_ready));

  // R6: a pixel is consumed only with a word handoff
  p_take_on_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (out_valid && out_ready));

  // R7: a stalled word is held
  p_hold_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  // R5: the stored pair pixel changes only when the first word is taken
  p_held_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && take_first) |=> $stable(held));
endmodule

// File: tb/sim_pix_bus_packer.sv
module sim_pix_bus_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_depth = 2'd1;
  logic [1:0]  cfg_lanes = 2'd0;
  logic [1:0]  cfg_fmt = 2'd1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_pix = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_word;
  logic        cfg_err;

  int total = 0;
  int fails = 0;
  logic [23:0] px [4];

  always #5 clk = ~clk;

  pix_bus_packer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_lanes(cfg_lanes),
    .cfg_fmt(cfg_fmt), .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .cfg_err(cfg_err)
  );

  function automatic int dbits(int d);
    int t [4] = '{12, 16, 18, 24};
    return t[d];
  endfunction

  function automatic int lbits(int m);
    int t [4] = '{8, 9, 12, 16};
    return t[m];
  endfunction

  // bit j of word k = string bit at distance k*L + (L-1-j) from its MSB
  function automatic logic [15:0] exp_word(int b, int l, logic [23:0] a, logic [23:0] c, int k);
    logic [15:0] w = '0;
    for (int j = 0; j < l; j++) begin
      int pos = k * l + (l - 1 - j);
      if (pos < b) w[j] = a[b - 1 - pos];
      else         w[j] = c[b - 1 - (pos - b)];
    end
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] obs();
    return {13'd0, cfg_err, out_valid, in_ready, out_word};
  endfunction

  function automatic logic [31:0] want(logic v, logic r, logic [15:0] w);
    return {13'd0, 1'b0, v, r, w};
  endfunction

  // drives n pixels from px through one configuration, checking every word
  task automatic run_case(string req, int d, int m, int f, int n);
    int b = dbits(d);
    int l = lbits(m);
    int c = (f == 0) ? 1 : (f == 1) ? 2 : 3;
    cfg_depth = 2'(d); cfg_lanes = 2'(m); cfg_fmt = 2'(f);
    in_valid = 1'b1; out_ready = 1'b1;
    if (f == 3) begin
      for (int p = 0; p < n; p += 2) begin
        for (int k = 0; k < 3; k++) begin
          in_pix = (k == 0) ? px[p] : px[p+1];
          #1 chk(req, obs(), want(1'b1, k != 1, exp_word(b, l, px[p], px[p+1], k)));
          @(negedge clk);
        end
      end
    end else begin
      for (int p = 0; p < n; p++) begin
        in_pix = px[p];
        for (int k = 0; k < c; k++) begin
          #1 chk(req, obs(), want(1'b1, k == c - 1, exp_word(b, l, px[p], 24'd0, k)));
          @(negedge clk);
        end
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    #1 chk("R9 reset", obs(), want(1'b0, 1'b0, 16'h0000));
  endtask

  task automatic t_idle;
    cfg_depth = 2'd3; cfg_lanes = 2'd0; cfg_fmt = 2'd2; in_valid = 1'b0; in_pix = 24'h777777;
    #1 chk("R7 idle", obs(), want(1'b0, 1'b0, 16'h0077));
    @(negedge clk);
  endtask

  task automatic t_chunked;
    px[0] = 24'h0012F0; px[1] = 24'h00BEEF;
    run_case("R3 16b/8 high byte first", 1, 0, 1, 2);
    px[0] = 24'h123456; px[1] = 24'hA1B2C3;
    run_case("R3 24b/8", 3, 0, 2, 2);
    px[0] = 24'h02A5C3; px[1] = 24'h01FFFF;
    run_case("R3 18b/9", 2, 1, 1, 2);
    px[0] = 24'hFEDCBA;
    run_case("R3 24b/12", 3, 2, 1, 1);
  endtask

  task automatic t_single;
    px[0] = 24'h00BEEF; px[1] = 24'h000001;
    run_case("R4 16b/16", 1, 3, 0, 2);
    px[0] = 24'h000ABC;
    run_case("R4 12b/12", 0, 2, 0, 1);
  endtask

  task automatic t_pair;
    px[0] = 24'h000ABC; px[1] = 24'h000123; px[2] = 24'h000FFF; px[3] = 24'h000001;
    run_case("R5 12b/8 pair", 0, 0, 3, 4);
    px[0] = 24'h03C0F3; px[1] = 24'h015A96;
    run_case("R5 18b/12 pair", 2, 2, 3, 2);
    px[0] = 24'h89ABCD; px[1] = 24'h135790;
    run_case("R5 24b/16 pair", 3, 3, 3, 2);
  endtask

  task automatic t_upper_ignored;
    px[0] = 24'hFF1234; px[1] = 24'hA5ABCD;
    run_case("R8 16b upper bits", 1, 0, 1, 2);
    px[0] = 24'hF55ABC;
    run_case("R8 12b upper bits", 0, 2, 0, 1);
  endtask

  task automatic t_backpressure;
    cfg_depth = 2'd1; cfg_lanes = 2'd0; cfg_fmt = 2'd1;
    in_pix = 24'h00C3A5; in_valid = 1'b1; out_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1 chk("R7 stall holds word", obs(), want(1'b1, 1'b0, 16'h00C3));
      @(negedge clk);
    end
    out_ready = 1'b1;
    #1 chk("R6 first of two not ready", obs(), want(1'b1, 1'b0, 16'h00C3));
    @(negedge clk);
    #1 chk("R6 last word ready", obs(), want(1'b1, 1'b1, 16'h00A5));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_illegal;
    in_pix = 24'h00BEEF; in_valid = 1'b1; out_ready = 1'b1;
    cfg_depth = 2'd1; cfg_lanes = 2'd1; cfg_fmt = 2'd1;
    for (int i = 0; i < 2; i++) begin
      #1 chk("R2 16b/9 silent", obs(), {13'd0, 1'b1, 1'b0, 1'b0, out_word});
      @(negedge clk);
    end
    cfg_depth = 2'd3; cfg_lanes = 2'd0; cfg_fmt = 2'd1;
    #1 chk("R1 24b/8 wrong format", {31'd0, cfg_err}, 32'd1);
    @(negedge clk);
    cfg_depth = 2'd0; cfg_lanes = 2'd3; cfg_fmt = 2'd3;
    #1 chk("R1 12b/16 no format", {31'd0, cfg_err}, 32'd1);
    @(negedge clk);
    cfg_depth = 2'd0; cfg_lanes = 2'd0; cfg_fmt = 2'd3;
    #1 chk("R1 12b/8 pair legal", {31'd0, cfg_err}, 32'd0);
    in_valid = 1'b0;
    @(negedge clk);
    cfg_depth = 2'd1; cfg_lanes = 2'd0; cfg_fmt = 2'd1; in_valid = 1'b1;
    #1 chk("R2 no advance while illegal", obs(), want(1'b1, 1'b0, 16'h00BE));
    @(negedge clk);
    #1 chk("R2 resumes", obs(), want(1'b1, 1'b1, 16'h00EF));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_chunked();
    t_single();
    t_pair();
    t_upper_ignored();
    t_backpressure();
    t_illegal();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule